// File: doc/BRIEF.md
# Vectored Trap Entry Controller

This block sits beside the instruction pipeline. At each instruction boundary it decides whether to take a trap. Three kinds of request can be pending at that boundary: a vector of instruction-induced exceptions, an external interrupt with a 4-bit level, and a software trap with a 7-bit number. When any request can be accepted, the block picks one winner and holds back the commit of the boundary instruction. On the next clock edge it produces the whole trap entry at once: the type number, the handler fetch address and the next fetch address, the advanced window pointer, and two register-file writes. The two writes store the interrupted PC and next PC into the new window.

The handler address is taken from the trap base register. Its top 20 bits are kept and combined with the 8-bit type number, and each table slot is 16 bytes, which is four instructions. Types below 0x80 are hardware traps and types from 0x80 upward are software traps. Taking a trap also clears an internal traps-enabled flag and sets supervisor mode. A separate return strobe undoes both.

Top module: `trap_entry_ctrl`

## Requirements
- R1: Requests are evaluated only in a cycle where `boundary` is 1. Without it, `trap_taken` stays 0 on the next cycle and the enable and mode state are unchanged.
- R2: Exception input i has type i+1. The lowest set index wins. Any exception beats a software trap, and a software trap beats an interrupt.
- R3: A software trap has type 0x80 OR `sw_num`, so it always lands in the upper half of the table.
- R4: An interrupt is accepted only when traps are enabled and the level is nonzero and either greater than `pil` or equal to 15. Its type is 0x10 plus the level.
- R5: On a taken trap, `fetch_pc` is `{tbr[31:12], type, 4'b0000}` and `fetch_npc` is `fetch_pc + 4`.
- R6: On a taken trap, `new_cwp` is `(cwp + 1) mod NWIN`, computed from the value sampled at the boundary.
- R7: For exactly one cycle after a taken trap, the PC write port stores the sampled `pc` into local 1 of window `new_cwp`. In the same cycle, the next-PC port stores the sampled `npc` into local 2 of the same window.
- R8: `insn_commit` is 1 exactly when `boundary` is 1 and no trap is taken in that cycle, so a trapping instruction never commits.
- R9: A taken trap clears `traps_enabled` and sets `supervisor` on the next cycle. A `trap_return` pulse sets `traps_enabled` and clears `supervisor`. Reset leaves `traps_enabled` 0 and `supervisor` 1.
- R10: After reset, `trap_taken` and both write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | An instruction is about to execute |
| exc_req | input | NEXC | Pending exceptions, index 0 highest priority |
| irq_level | input | 4 | External interrupt level, 0 means none |
| pil | input | 4 | Processor interrupt level threshold |
| sw_req | input | 1 | Software trap requested |
| sw_num | input | 7 | Software trap number |
| trap_return | input | 1 | Re-enable traps and leave supervisor mode |
| pc | input | 32 | Current PC |
| npc | input | 32 | Next PC |
| cwp | input | CW | Current window pointer |
| tbr | input | 32 | Trap base register |
| insn_commit | output | 1 | Boundary instruction may commit |
| trap_taken | output | 1 | Trap entry strobe |
| trap_type | output | 8 | Selected trap type |
| fetch_pc | output | 32 | Handler fetch address |
| fetch_npc | output | 32 | Handler next fetch address |
| new_cwp | output | CW | Advanced window pointer |
| supervisor | output | 1 | Supervisor mode flag |
| traps_enabled | output | 1 | Traps-enabled flag |
| sv_pc_en | output | 1 | PC save write enable |
| sv_pc_win | output | CW | PC save window |
| sv_pc_idx | output | 3 | PC save local index (1) |
| sv_pc_data | output | 32 | Saved PC |
| sv_npc_en | output | 1 | Next-PC save write enable |
| sv_npc_win | output | CW | Next-PC save window |
| sv_npc_idx | output | 3 | Next-PC save local index (2) |
| sv_npc_data | output | 32 | Saved next PC |

## Verification
The bench walks every exception mask, with and without a software trap and with a rotating interrupt level. A reversed priority encoder or a software trap placed above the exceptions would report the wrong type. A full sweep of level against threshold exposes an off-by-one comparison or a missing level-15 override, because an interrupt would then be accepted or refused wrongly. The window pointer is driven through its top value, so an advance that does not wrap would produce an out-of-range window. The trap base register is driven with nonzero low bits, which would leak into a handler address that failed to mask them. Trials that run with traps disabled, plus a request presented without a boundary, catch an interrupt taken while traps are off and a trap raised between instructions.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XLEN    = 32;
  localparam int TYPE_W  = 8;
  localparam int LVL_W   = 4;
  localparam int SWN_W   = 7;
  localparam int LIDX_W  = 3;
  localparam logic [LIDX_W-1:0] LOC_PC  = 3'd1;
  localparam logic [LIDX_W-1:0] LOC_NPC = 3'd2;
  localparam logic [TYPE_W-1:0] IRQ_BASE = 8'h10;
  localparam logic [TYPE_W-1:0] SW_BASE  = 8'h80;

  // exception index -> trap type (lower half, starting at 1)
  function automatic logic [TYPE_W-1:0] exc_type(input int idx);
    return TYPE_W'(idx + 1);
  endfunction

  // interrupt admission rule
  function automatic logic irq_accept(input logic et, input logic [LVL_W-1:0] lvl,
                                      input logic [LVL_W-1:0] thr);
    return et && (lvl != '0) && ((lvl > thr) || (lvl == 4'hF));
  endfunction

  // table vector from base register and type
  function automatic logic [XLEN-1:0] vec_addr(input logic [XLEN-1:0] base,
                                               input logic [TYPE_W-1:0] ttype);
    return {base[XLEN-1:12], ttype, 4'b0000};
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int NEXC = 8
) (
  input  logic [NEXC-1:0]   exc_req,
  input  logic              sw_req,
  input  logic [SWN_W-1:0]  sw_num,
  input  logic              irq_ok,
  input  logic [LVL_W-1:0]  irq_level,
  output logic              any,
  output logic [TYPE_W-1:0] sel_type,
  output logic              g_exc,
  output logic              g_sw,
  output logic              g_irq
);
  logic [TYPE_W-1:0] exc_sel;

  // lowest index wins: scan from the top down so the last hit is the lowest
  always_comb begin
    exc_sel = '0;
    for (int i = NEXC - 1; i >= 0; i--) begin
      if (exc_req[i]) exc_sel = exc_type(i);
    end
  end

  assign g_exc = |exc_req;
  assign g_sw  = !g_exc && sw_req;
  assign g_irq = !g_exc && !sw_req && irq_ok;
  assign any   = g_exc || g_sw || g_irq;

  always_comb begin
    if (g_exc)      sel_type = exc_sel;
    else if (g_sw)  sel_type = SW_BASE | {1'b0, sw_num};
    else if (g_irq) sel_type = IRQ_BASE | {4'b0, irq_level};
    else            sel_type = '0;
  end
endmodule

// File: rtl/trap_vector.sv
module trap_vector
  import trap_pkg::*;
(
  input  logic [XLEN-1:0]   tbr,
  input  logic [TYPE_W-1:0] ttype,
  output logic [XLEN-1:0]   vec,
  output logic [XLEN-1:0]   vec_n
);
  assign vec   = vec_addr(tbr, ttype);
  assign vec_n = vec + XLEN'(4);
endmodule

// File: rtl/trap_window.sv
module trap_window #(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic [CW-1:0] cwp,
  output logic [CW-1:0] nxt
);
  function automatic logic [CW-1:0] advance(input logic [CW-1:0] w);
    return (int'(w) == NWIN - 1) ? '0 : w + CW'(1);
  endfunction

  assign nxt = advance(cwp);
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int NEXC = 8,
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic [NEXC-1:0]   exc_req,
  input  logic [3:0]        irq_level,
  input  logic [3:0]        pil,
  input  logic              sw_req,
  input  logic [6:0]        sw_num,
  input  logic              trap_return,
  input  logic [31:0]       pc,
  input  logic [31:0]       npc,
  input  logic [CW-1:0]     cwp,
  input  logic [31:0]       tbr,
  output logic              insn_commit,
  output logic              trap_taken,
  output logic [7:0]        trap_type,
  output logic [31:0]       fetch_pc,
  output logic [31:0]       fetch_npc,
  output logic [CW-1:0]     new_cwp,
  output logic              supervisor,
  output logic              traps_enabled,
  output logic              sv_pc_en,
  output logic [CW-1:0]     sv_pc_win,
  output logic [2:0]        sv_pc_idx,
  output logic [31:0]       sv_pc_data,
  output logic              sv_npc_en,
  output logic [CW-1:0]     sv_npc_win,
  output logic [2:0]        sv_npc_idx,
  output logic [31:0]       sv_npc_data
);
  // named internal events, visible to the checker
  logic              irq_ok;
  logic              req_any;
  logic              take_now;
  logic              g_exc, g_sw, g_irq;
  logic [TYPE_W-1:0] sel_type;
  logic [XLEN-1:0]   vec, vec_n;
  logic [CW-1:0]     cwp_nxt;
  logic              et_q, s_q;

  assign irq_ok   = irq_accept(et_q, irq_level, pil);
  assign take_now = boundary && req_any;

  trap_arbiter #(.NEXC(NEXC)) u_arb (
    .exc_req  (exc_req),
    .sw_req   (sw_req),
    .sw_num   (sw_num),
    .irq_ok   (irq_ok),
    .irq_level(irq_level),
    .any      (req_any),
    .sel_type (sel_type),
    .g_exc    (g_exc),
    .g_sw     (g_sw),
    .g_irq    (g_irq)
  );

  trap_vector u_vec (
    .tbr  (tbr),
    .ttype(sel_type),
    .vec  (vec),
    .vec_n(vec_n)
  );

  trap_window #(.NWIN(NWIN), .CW(CW)) u_win (
    .cwp(cwp),
    .nxt(cwp_nxt)
  );

  assign insn_commit = boundary && !req_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_taken  <= 1'b0;
      trap_type   <= '0;
      fetch_pc    <= '0;
      fetch_npc   <= '0;
      new_cwp     <= '0;
      sv_pc_data  <= '0;
      sv_npc_data <= '0;
      et_q        <= 1'b0;
      s_q         <= 1'b1;
    end else begin
      trap_taken <= take_now;
      if (take_now) begin
        trap_type   <= sel_type;
        fetch_pc    <= vec;
        fetch_npc   <= vec_n;
        new_cwp     <= cwp_nxt;
        sv_pc_data  <= pc;
        sv_npc_data <= npc;
        et_q        <= 1'b0;
        s_q         <= 1'b1;
      end else if (trap_return) begin
        et_q <= 1'b1;
        s_q  <= 1'b0;
      end
    end
  end

  assign traps_enabled = et_q;
  assign supervisor    = s_q;
  assign sv_pc_en      = trap_taken;
  assign sv_npc_en     = trap_taken;
  assign sv_pc_win     = new_cwp;
  assign sv_npc_win    = new_cwp;
  assign sv_pc_idx     = LOC_PC;
  assign sv_npc_idx    = LOC_NPC;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int NEXC = 8,
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          boundary,
  input logic [NEXC-1:0] exc_req,
  input logic [3:0]    irq_level,
  input logic [3:0]    pil,
  input logic          sw_req,
  input logic          g_exc,
  input logic          g_sw,
  input logic          g_irq,
  input logic          take_now,
  input logic          insn_commit,
  input logic          trap_taken,
  input logic [7:0]    trap_type,
  input logic [31:0]   tbr,
  input logic [31:0]   fetch_pc,
  input logic [31:0]   fetch_npc,
  input logic [CW-1:0] cwp,
  input logic [CW-1:0] new_cwp,
  input logic          traps_enabled,
  input logic          supervisor,
  input logic          sv_pc_en,
  input logic          sv_npc_en
);
  a_r2_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({g_exc, g_sw, g_irq}));

  a_r2_exc_first: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && |exc_req) |=> (trap_taken && trap_type != 8'h00 && trap_type < 8'h10));

  a_r3_sw_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && exc_req == '0 && sw_req) |=> trap_type[7]);

  a_r4_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    g_irq |-> (traps_enabled && irq_level != 4'd0 && (irq_level > pil || irq_level == 4'hF)));

  a_r1_no_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> !trap_taken);

  a_r5_vector: assert property (@(posedge clk) disable iff (!rst_n)
    take_now |=> (fetch_pc[3:0] == 4'd0 && fetch_pc[31:12] == $past(tbr[31:12])
                  && fetch_pc[11:4] == trap_type && fetch_npc == fetch_pc + 32'd4));

  a_r6_window: assert property (@(posedge clk) disable iff (!rst_n)
    take_now |=> (int'(new_cwp) == (int'($past(cwp)) + 1) % NWIN));

  a_r7_save_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (sv_pc_en == trap_taken) && (sv_npc_en == trap_taken));

  a_r8_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    insn_commit |=> !trap_taken);

  a_r9_entry_mode: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> (!traps_enabled && supervisor));
endmodule

bind trap_entry_ctrl trap_entry_chk #(.NEXC(NEXC), .NWIN(NWIN), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .exc_req(exc_req),
  .irq_level(irq_level), .pil(pil), .sw_req(sw_req),
  .g_exc(g_exc), .g_sw(g_sw), .g_irq(g_irq), .take_now(take_now),
  .insn_commit(insn_commit), .trap_taken(trap_taken), .trap_type(trap_type),
  .tbr(tbr), .fetch_pc(fetch_pc), .fetch_npc(fetch_npc), .cwp(cwp),
  .new_cwp(new_cwp), .traps_enabled(traps_enabled), .supervisor(supervisor),
  .sv_pc_en(sv_pc_en), .sv_npc_en(sv_npc_en)
);

// File: tb/tb_trap_entry_ctrl.sv
module tb_trap_entry_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NEXC = 8;
  localparam int NWIN = 8;
  localparam int CW   = $clog2(NWIN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary = 1'b0;
  logic [NEXC-1:0] exc_req = '0;
  logic [3:0] irq_level = '0, pil = '0;
  logic sw_req = 1'b0;
  logic [6:0] sw_num = '0;
  logic trap_return = 1'b0;
  logic [31:0] pc = '0, npc = '0, tbr = '0;
  logic [CW-1:0] cwp = '0;
  logic insn_commit, trap_taken, supervisor, traps_enabled;
  logic [7:0] trap_type;
  logic [31:0] fetch_pc, fetch_npc, sv_pc_data, sv_npc_data;
  logic [CW-1:0] new_cwp, sv_pc_win, sv_npc_win;
  logic sv_pc_en, sv_npc_en;
  logic [2:0] sv_pc_idx, sv_npc_idx;

  int n_checks = 0;
  int n_errors = 0;
  logic et_m = 1'b0;
  logic s_m = 1'b1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  trap_entry_ctrl #(.NEXC(NEXC), .NWIN(NWIN)) dut (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .exc_req(exc_req),
    .irq_level(irq_level), .pil(pil), .sw_req(sw_req), .sw_num(sw_num),
    .trap_return(trap_return), .pc(pc), .npc(npc), .cwp(cwp), .tbr(tbr),
    .insn_commit(insn_commit), .trap_taken(trap_taken), .trap_type(trap_type),
    .fetch_pc(fetch_pc), .fetch_npc(fetch_npc), .new_cwp(new_cwp),
    .supervisor(supervisor), .traps_enabled(traps_enabled),
    .sv_pc_en(sv_pc_en), .sv_pc_win(sv_pc_win), .sv_pc_idx(sv_pc_idx),
    .sv_pc_data(sv_pc_data), .sv_npc_en(sv_npc_en), .sv_npc_win(sv_npc_win),
    .sv_npc_idx(sv_npc_idx), .sv_npc_data(sv_npc_data)
  );

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected type, 0 = no trap
  function automatic int model_type(input logic [NEXC-1:0] m, input logic s,
                                    input int n, input int lvl, input int thr, input logic et);
    for (int i = 0; i < NEXC; i++) if (m[i]) return i + 1;
    if (s) return 128 + n;
    if (et && lvl != 0 && (lvl > thr || lvl == 15)) return 16 + lvl;
    return 0;
  endfunction

  task automatic trial(input logic [NEXC-1:0] m, input logic s, input int n,
                       input int lvl, input int thr, input logic ret, input int k);
    int et_typ;
    logic [31:0] ebase;
    @(negedge clk);
    trap_return = ret;
    if (ret) begin et_m = 1'b1; s_m = 1'b0; end
    @(negedge clk);
    trap_return = 1'b0;
    exc_req = m; sw_req = s; sw_num = 7'(n); irq_level = 4'(lvl); pil = 4'(thr);
    pc = 32'h4000_0000 + 32'(k) * 32'd8; npc = pc + 32'd4;
    cwp = CW'(k % NWIN);
    tbr = 32'h8000_0000 + (32'(k) << 12) + 32'h5A5;
    boundary = 1'b1;
    et_typ = model_type(m, s, n, lvl, thr, et_m);
    #1;
    check(insn_commit == (et_typ == 0), "R8 commit", insn_commit, et_typ == 0);
    @(negedge clk);
    boundary = 1'b0;
    check(trap_taken == (et_typ != 0), "R2 taken", trap_taken, et_typ != 0);
    if (et_typ != 0) begin
      ebase = {tbr[31:12], 12'h000} + 32'(et_typ) * 32'd16;
      if (et_typ >= 128)     check(trap_type == 8'(et_typ), "R3 sw type", trap_type, et_typ);
      else if (et_typ >= 16) check(trap_type == 8'(et_typ), "R4 irq type", trap_type, et_typ);
      else                   check(trap_type == 8'(et_typ), "R2 exc type", trap_type, et_typ);
      check(fetch_pc == ebase, "R5 vector", fetch_pc, ebase);
      check(fetch_npc == ebase + 32'd4, "R5 next vector", fetch_npc, ebase + 32'd4);
      check(int'(new_cwp) == (k + 1) % NWIN, "R6 window", new_cwp, (k + 1) % NWIN);
      check(sv_pc_en && sv_pc_idx == 3'd1 && sv_pc_win == new_cwp && sv_pc_data == pc,
            "R7 pc save", sv_pc_data, pc);
      check(sv_npc_en && sv_npc_idx == 3'd2 && sv_npc_win == new_cwp && sv_npc_data == npc,
            "R7 npc save", sv_npc_data, npc);
      et_m = 1'b0; s_m = 1'b1;
    end else begin
      check(!sv_pc_en && !sv_npc_en, "R7 no save", sv_pc_en, 0);
    end
    check(traps_enabled == et_m && supervisor == s_m, "R9 mode",
          {traps_enabled, supervisor}, {et_m, s_m});
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int k = 0;
    repeat (3) @(negedge clk);
    // R10 / R9 reset state
    check(!trap_taken && !sv_pc_en && !sv_npc_en, "R10 reset outputs", trap_taken, 0);
    check(!traps_enabled && supervisor, "R9 reset mode", {traps_enabled, supervisor}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: requests without a boundary are ignored
    exc_req = 8'hFF; sw_req = 1'b1; irq_level = 4'hF;
    @(negedge clk);
    @(negedge clk);
    check(!trap_taken, "R1 no boundary", trap_taken, 0);
    check(!traps_enabled && supervisor, "R1 state kept", {traps_enabled, supervisor}, 2'b01);
    // main sweep: every exception mask, with and without software trap
    for (int m = 0; m < (1 << NEXC); m++) begin
      for (int s = 0; s < 2; s++) begin
        trial(NEXC'(m), s[0], (m * 5 + s) % 128, (m + s * 7) % 16, 7, ((m + s) % 3) != 0, k);
        k++;
      end
    end
    // interrupt level against threshold, traps enabled
    for (int lv = 0; lv < 16; lv++) begin
      for (int th = 0; th < 16; th++) begin
        trial('0, 1'b0, 0, lv, th, 1'b1, k);
        k++;
      end
    end
    // interrupt with traps disabled (previous trap cleared the flag)
    trial('0, 1'b0, 0, 15, 0, 1'b1, k); k++;
    trial('0, 1'b0, 0, 15, 0, 1'b0, k); k++;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule